// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a legacy peripheral cluster. It occupies two adjacent byte locations on an ISA-style I/O bus. The even location holds an index and the odd location moves data to or from the register that the index selects. Behind the port are three 8-bit configuration registers: function enable, function address select, and power/test. Their values drive output ports continuously, so the downstream decode logic reads them directly and needs no handshake.

On reset, the registers load a set of values chosen by a 5-bit strap input from a fixed 32-entry table. The first read of the index location after reset returns an identification byte. Once firmware has found the part, it selects registers and writes them. A lock bit in the power/test register freezes all three registers until the next reset.

Top module: `sio_cfg_port`

## Requirements
- R1: An access hits the port only when address bits [ADDR_W-1:1] equal those of BASE_ADDR (default 0x398). Address bit 0 = 0 selects the index location and bit 0 = 1 selects the data location. An access that misses changes no state and produces no read response.
- R2: A hit read raises io_rvalid for exactly one cycle on the clock edge after the read, with io_rdata valid in that cycle. Without a hit read, io_rvalid is 0 and io_rdata is 0x00.
- R3: The first index-location read after reset returns 0x88. Every later index read returns the selected index, which is 0x00 right after reset.
- R4: Any hit write to the index location ends the identification phase, so the next index read returns the written index and not 0x88.
- R5: A data write stores the byte in the selected register: index 0 is enable, 1 is address select, 2 is power/test. The new value appears on the matching cfg_* output one cycle later and is returned by a data read.
- R6: A data write while the index is 3 or higher changes no register, and a data read while the index is 3 or higher returns 0x00.
- R7: Reset sets the index to 0, restarts the identification phase and loads the registers from the strap table as (enable, address, power). Strap 0 gives (4F,10,00), 1 gives (4F,11,00), 3 gives (4F,39,00), 6 gives (4B,00,00), 9 gives (4B,09,00), 12 gives (0F,10,00), 16 gives (49,00,00), 20 gives (07,10,00), 24 gives (47,10,00), 30 gives (08,10,00) and 31 gives (00,10,02).
- R8: While bit 6 of the power/test register is 1, data writes to all three registers are ignored until the next reset. The write that sets the bit does take effect.
- R9: The index register holds all 8 bits written to it, and an index read returns the full byte (for example 0xA5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 5 | Strap value that selects the reset register set |
| io_addr | input | ADDR_W | Bus I/O address |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after a hit read |
| cfg_enable | output | 8 | Function enable register |
| cfg_addrsel | output | 8 | Function address select register |
| cfg_power | output | 8 | Power/test register (bit 6 is the lock) |

## Verification
The bench builds the port with its defaults: ADDR_W of 16 and a base of 0x398. This puts the index location at 0x398 and the data location at 0x399. With these values, neighbouring addresses that differ only in upper bits (0x39A, 0x2F8) serve as misses. Changing the strap between resets reaches eleven rows of the reset table, including both end entries and each run of equal enable values. The full 8-bit index lets the bench select indexes 3 and 0xA5 and so exercise the unmapped-register paths.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 5;
  localparam int NUM_REGS = 3;
  localparam int LOCK_BIT = 6;
  localparam logic [BYTE_W-1:0] CHIP_ID = 8'h88;

  // Register set, index 0 in the low byte
  typedef struct packed {
    logic [BYTE_W-1:0] power;
    logic [BYTE_W-1:0] addrsel;
    logic [BYTE_W-1:0] enable;
  } cfg_set_t;
endpackage

// File: rtl/sio_strap_rom.sv
module sio_strap_rom
  import sio_cfg_pkg::*;
(
  input  logic [STRAP_W-1:0] strap,
  output cfg_set_t           reset_set
);
  // Address-select reset bytes, entry 0 in the low byte
  localparam logic [32*BYTE_W-1:0] ADDR_TBL = {
    8'h10, 8'h10, 8'h38, 8'h24, 8'h39, 8'h11, 8'h11, 8'h10,
    8'h24, 8'h39, 8'h11, 8'h10, 8'h00, 8'h01, 8'h01, 8'h00,
    8'h24, 8'h39, 8'h11, 8'h10, 8'h08, 8'h08, 8'h09, 8'h01,
    8'h01, 8'h00, 8'h38, 8'h24, 8'h39, 8'h11, 8'h11, 8'h10
  };

  logic [BYTE_W-1:0] en_val;

  // Enable bytes come in runs of equal value
  always_comb begin
    if (strap < 5'd6)       en_val = 8'h4F;
    else if (strap < 5'd12) en_val = 8'h4B;
    else if (strap < 5'd16) en_val = 8'h0F;
    else if (strap < 5'd20) en_val = 8'h49;
    else if (strap < 5'd24) en_val = 8'h07;
    else if (strap < 5'd30) en_val = 8'h47;
    else if (strap == 5'd30) en_val = 8'h08;
    else                    en_val = 8'h00;
  end

  always_comb begin
    reset_set.enable  = en_val;
    reset_set.addrsel = ADDR_TBL[strap*BYTE_W +: BYTE_W];
    reset_set.power   = (strap == 5'd31) ? 8'h02 : 8'h00;
  end
endmodule

// File: rtl/sio_index_ctrl.sv
module sio_index_ctrl
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic              idx_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] sel_index,
  output logic              id_pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_index  <= '0;
      id_pending <= 1'b1;
    end else begin
      if (idx_wr) sel_index <= wdata;
      if (idx_wr || idx_rd) id_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfg_set_t          reset_set,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] sel_index,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_set_t          cfg
);
  localparam int FLAT_W = NUM_REGS * BYTE_W;

  logic [FLAT_W-1:0] init_flat;
  logic [FLAT_W-1:0] cur_flat;
  logic              locked;

  assign init_flat = reset_set;
  assign cfg       = cur_flat;
  assign locked    = cur_flat[2*BYTE_W + LOCK_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        cur_flat[i*BYTE_W +: BYTE_W] <= init_flat[i*BYTE_W +: BYTE_W];
      else if (data_wr && !locked && sel_index == BYTE_W'(i))
        cur_flat[i*BYTE_W +: BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [BYTE_W-1:0]  io_wdata,
  output logic [BYTE_W-1:0]  io_rdata,
  output logic               io_rvalid,
  output logic [BYTE_W-1:0]  cfg_enable,
  output logic [BYTE_W-1:0]  cfg_addrsel,
  output logic [BYTE_W-1:0]  cfg_power
);
  logic              hit;
  logic              idx_wr, idx_rd, data_wr, data_rd;
  logic [BYTE_W-1:0] sel_index;
  logic              id_pending;
  cfg_set_t          reset_set;
  cfg_set_t          cfg;
  logic [BYTE_W-1:0] rd_mux;

  assign hit     = (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
  assign idx_wr  = hit && io_wr && !io_addr[0];
  assign idx_rd  = hit && io_rd && !io_addr[0];
  assign data_wr = hit && io_wr &&  io_addr[0];
  assign data_rd = hit && io_rd &&  io_addr[0];

  sio_strap_rom u_rom (
    .strap     (strap),
    .reset_set (reset_set)
  );

  sio_index_ctrl u_idx (
    .clk        (clk),
    .rst        (rst),
    .idx_wr     (idx_wr),
    .idx_rd     (idx_rd),
    .wdata      (io_wdata),
    .sel_index  (sel_index),
    .id_pending (id_pending)
  );

  sio_cfg_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .reset_set (reset_set),
    .data_wr   (data_wr),
    .sel_index (sel_index),
    .wdata     (io_wdata),
    .cfg       (cfg)
  );

  always_comb begin
    rd_mux = '0;
    if (idx_rd) begin
      rd_mux = id_pending ? CHIP_ID : sel_index;
    end else if (data_rd) begin
      case (sel_index)
        8'd0:    rd_mux = cfg.enable;
        8'd1:    rd_mux = cfg.addrsel;
        8'd2:    rd_mux = cfg.power;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rdata  <= rd_mux;
      io_rvalid <= idx_rd || data_rd;
    end
  end

  assign cfg_enable  = cfg.enable;
  assign cfg_addrsel = cfg.addrsel;
  assign cfg_power   = cfg.power;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0398
)(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic [7:0]        cfg_enable,
  input logic [7:0]        cfg_addrsel,
  input logic [7:0]        cfg_power,
  input logic [7:0]        sel_index
);
  logic at_port;
  assign at_port = (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

  a_r1_miss_no_change: assert property (@(posedge clk) disable iff (rst)
    (!at_port) |=> ($stable(cfg_enable) && $stable(cfg_addrsel) &&
                    $stable(cfg_power) && !io_rvalid));

  a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (at_port && io_rd) |=> io_rvalid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(at_port && io_rd) |=> (!io_rvalid && io_rdata == 8'h00));

  a_r5_enable_write: assert property (@(posedge clk) disable iff (rst)
    (at_port && io_wr && io_addr[0] && sel_index == 8'd0 && !cfg_power[6])
      |=> cfg_enable == $past(io_wdata));

  a_r6_bad_index_read: assert property (@(posedge clk) disable iff (rst)
    (at_port && io_rd && io_addr[0] && sel_index > 8'd2) |=> io_rdata == 8'h00);

  a_r8_lock_freezes: assert property (@(posedge clk) disable iff (rst)
    cfg_power[6] |=> ($stable(cfg_enable) && $stable(cfg_addrsel) && $stable(cfg_power)));

  a_r9_index_write: assert property (@(posedge clk) disable iff (rst)
    (at_port && io_wr && !io_addr[0]) |=> sel_index == $past(io_wdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .io_rvalid   (io_rvalid),
  .cfg_enable  (cfg_enable),
  .cfg_addrsel (cfg_addrsel),
  .cfg_power   (cfg_power),
  .sel_index   (sel_index)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam logic [15:0] IDX_A  = 16'h0398;
  localparam logic [15:0] DAT_A  = 16'h0399;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap = 5'd1;
  logic [15:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       io_rvalid;
  logic [7:0] cfg_enable, cfg_addrsel, cfg_power;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst(rst), .strap(strap), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_enable(cfg_enable), .cfg_addrsel(cfg_addrsel), .cfg_power(cfg_power)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    strap = s; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // Returns data and valid sampled the cycle after the read edge
  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic check_regs(input string tag, input logic [7:0] e, input logic [7:0] a,
                            input logic [7:0] p);
    chk({tag, " enable"}, cfg_enable, e);
    chk({tag, " addrsel"}, cfg_addrsel, a);
    chk({tag, " power"}, cfg_power, p);
  endtask

  task automatic t_reset_and_id();
    logic [7:0] d; logic v;
    do_reset(5'd1);
    @(negedge clk);
    check_regs("R7 strap1", 8'h4F, 8'h11, 8'h00);
    chk("R2 idle rvalid", io_rvalid, 0);
    chk("R2 idle rdata", io_rdata, 8'h00);
    bus_rd(IDX_A, d, v);
    chk("R2 rvalid", v, 1);
    chk("R3 first index read id", d, 8'h88);
    @(negedge clk);
    chk("R2 rvalid one cycle", io_rvalid, 0);
    bus_rd(IDX_A, d, v);
    chk("R3 second read index 0", d, 8'h00);
  endtask

  task automatic t_strap_table();
    do_reset(5'd0);  @(negedge clk); check_regs("R7 strap0",  8'h4F, 8'h10, 8'h00);
    do_reset(5'd3);  @(negedge clk); check_regs("R7 strap3",  8'h4F, 8'h39, 8'h00);
    do_reset(5'd6);  @(negedge clk); check_regs("R7 strap6",  8'h4B, 8'h00, 8'h00);
    do_reset(5'd9);  @(negedge clk); check_regs("R7 strap9",  8'h4B, 8'h09, 8'h00);
    do_reset(5'd12); @(negedge clk); check_regs("R7 strap12", 8'h0F, 8'h10, 8'h00);
    do_reset(5'd16); @(negedge clk); check_regs("R7 strap16", 8'h49, 8'h00, 8'h00);
    do_reset(5'd20); @(negedge clk); check_regs("R7 strap20", 8'h07, 8'h10, 8'h00);
    do_reset(5'd24); @(negedge clk); check_regs("R7 strap24", 8'h47, 8'h10, 8'h00);
    do_reset(5'd30); @(negedge clk); check_regs("R7 strap30", 8'h08, 8'h10, 8'h00);
    do_reset(5'd31); @(negedge clk); check_regs("R7 strap31", 8'h00, 8'h10, 8'h02);
  endtask

  task automatic t_index_write_ends_id();
    logic [7:0] d; logic v;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'h02);
    bus_rd(IDX_A, d, v);
    chk("R4 index read after write", d, 8'h02);
  endtask

  task automatic t_data_rw();
    logic [7:0] d; logic v;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'h00); bus_wr(DAT_A, 8'h5A);
    chk("R5 enable port", cfg_enable, 8'h5A);
    bus_wr(IDX_A, 8'h01); bus_wr(DAT_A, 8'hC3);
    chk("R5 addrsel port", cfg_addrsel, 8'hC3);
    bus_wr(IDX_A, 8'h02); bus_wr(DAT_A, 8'h81);
    chk("R5 power port", cfg_power, 8'h81);
    bus_rd(DAT_A, d, v);
    chk("R5 power readback", d, 8'h81);
    bus_wr(IDX_A, 8'h00);
    bus_rd(DAT_A, d, v);
    chk("R5 enable readback", d, 8'h5A);
  endtask

  task automatic t_bad_index();
    logic [7:0] d; logic v;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'h03); bus_wr(DAT_A, 8'hFF);
    check_regs("R6 write idx3 ignored", 8'h4F, 8'h11, 8'h00);
    bus_rd(DAT_A, d, v);
    chk("R6 read idx3 zero", d, 8'h00);
    chk("R6 read idx3 valid", v, 1);
    bus_wr(IDX_A, 8'hA5);
    bus_rd(IDX_A, d, v);
    chk("R9 full index readback", d, 8'hA5);
    bus_wr(DAT_A, 8'h77);
    check_regs("R6 write idxA5 ignored", 8'h4F, 8'h11, 8'h00);
  endtask

  task automatic t_addr_miss();
    logic [7:0] d; logic v;
    do_reset(5'd1);
    bus_wr(16'h02F8, 8'h01);
    bus_wr(16'h039B, 8'hEE);
    check_regs("R1 miss write ignored", 8'h4F, 8'h11, 8'h00);
    bus_rd(16'h039A, d, v);
    chk("R1 miss read no valid", v, 0);
    bus_rd(IDX_A, d, v);
    chk("R1 miss kept id phase", d, 8'h88);
  endtask

  task automatic t_lock();
    logic [7:0] d; logic v;
    do_reset(5'd1);
    bus_wr(IDX_A, 8'h02); bus_wr(DAT_A, 8'h40);
    chk("R8 lock write applies", cfg_power, 8'h40);
    bus_wr(DAT_A, 8'h00);
    chk("R8 power frozen", cfg_power, 8'h40);
    bus_wr(IDX_A, 8'h00); bus_wr(DAT_A, 8'h12);
    chk("R8 enable frozen", cfg_enable, 8'h4F);
    bus_wr(IDX_A, 8'h01); bus_wr(DAT_A, 8'h34);
    chk("R8 addrsel frozen", cfg_addrsel, 8'h11);
    bus_rd(IDX_A, d, v);
    chk("R8 index still writable", d, 8'h01);
    do_reset(5'd1);
    @(negedge clk);
    chk("R8 reset clears lock", cfg_power, 8'h00);
    bus_wr(IDX_A, 8'h00); bus_wr(DAT_A, 8'h12);
    chk("R8 writable after reset", cfg_enable, 8'h12);
  endtask

  initial begin
    t_reset_and_id();
    t_strap_table();
    t_index_write_ends_id();
    t_data_rw();
    t_bad_index();
    t_addr_miss();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule